// File: doc/BRIEF.md
# Gated Frequency-Counting ADC Backend

This block is the digital half of a voltage-to-frequency converter. An external oscillator, whose rate follows the analog input, drives `osc_i` with no timing relation to the system clock. When a start strobe is accepted, the block opens a counting window of a fixed number of system-clock cycles. That window stands for one base period Ts = 1/f0. The block then counts the oscillator's rising edges inside the window. The final count is the output code, so a rate of k·f0 yields a code near k, and any rate at or below one edge per window yields a code of 0 or 1.

The oscillator is brought into the clock domain through a synchroniser chain, and its rising edges are detected there. The oscillator must therefore run below half the system clock rate. The tally saturates at its largest code instead of wrapping, and an overflow flag records that saturation took place. When the window closes, the result is latched, a one-cycle done pulse is issued, and the code and flag stay unchanged until the next conversion completes. A start strobe that arrives while a window is open is ignored.

Top module: `vfc_edge_tally`

## Requirements
- R1: While reset is asserted and after it is released, before any conversion completes, `code_o` is 0, `ovf_o` is 0 and `done_o` is 0.
- R2: A start accepted at clock edge S opens a window that lasts exactly GATE_CYCLES cycles. `done_o` is then high for exactly one cycle, the cycle that follows edge S+GATE_CYCLES.
- R3: An oscillator rise is sampled high at clock edge t after being sampled low at edge t-1. It is counted if and only if S-1 <= t <= S+GATE_CYCLES-2. Rises sampled outside that range do not change the code.
- R4: A window that holds no counted rise gives code 0 with `ovf_o` low.
- R5: A window that holds k counted rises, with k <= 2^CNT_W-1, gives code k with `ovf_o` low. This includes k equal to the largest code.
- R6: A window that holds more than 2^CNT_W-1 counted rises gives the largest code (all ones) with `ovf_o` high.
- R7: A start strobe sampled while a window is open, including on the window's closing edge, is ignored. The window is not restarted and no extra done pulse appears.
- R8: `code_o` and `ovf_o` change only in the cycle where `done_o` is high, and hold their values in all other cycles.
- R9: The tally is cleared when a start is accepted. A result never includes rises or saturation from an earlier window, even when the new start is sampled during the done cycle of the previous conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; the gate length is counted in its cycles |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_i | input | 1 | Asynchronous oscillator output whose rate tracks the input voltage |
| start_i | input | 1 | Start strobe; opens a window when no window is open |
| code_o | output | CNT_W | Latched edge count of the last finished window |
| ovf_o | output | 1 | High when the last window's count saturated |
| done_o | output | 1 | One-cycle pulse marking a newly latched result |

## Verification
Two events can fall in the same cycle. The first is a rise counted on the window's final edge, at the same moment the result is latched, so the latched code has to include it. The second is a fresh start sampled in the cycle where the previous done pulse is high, so the tally clears while the old result is still being presented. The bench forces both by placing a rise at offset GATE_CYCLES-2 and then issuing the next start with no gap. The first code must count that rise, the second code must count only its own rises, and each done pulse must land on its predicted cycle.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_OPEN = 1'b1
    } gate_phase_e;

endpackage

// File: rtl/vfc_osc_sync.sv
module vfc_osc_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic osc_i,
    output logic rise_o
);

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[TOP-1:0], osc_i};
        st_d.prev  = st_q.chain[TOP];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.chain[TOP] & ~st_q.prev;

    // R3
    rise_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/vfc_gate_timer.sv
module vfc_gate_timer
    import vfc_pkg::*;
#(
    parameter int GATE_CYCLES = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic accept_o,
    output logic active_o,
    output logic last_o
);

    localparam int              CW       = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
    localparam logic [CW-1:0]   LAST_IDX = CW'(GATE_CYCLES - 1);

    typedef struct packed {
        gate_phase_e   phase;
        logic [CW-1:0] cnt;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        accept_o = (st_q.phase == PH_IDLE) && start_i;
        last_o   = (st_q.phase == PH_OPEN) && (st_q.cnt == LAST_IDX);
        active_o = (st_q.phase == PH_OPEN);
        st_d     = st_q;
        if (accept_o) begin
            st_d.phase = PH_OPEN;
            st_d.cnt   = '0;
        end else if (last_o) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
        end else if (active_o) begin
            st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    gate_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_OPEN) |-> (st_q.cnt <= LAST_IDX));

    // R2
    gate_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_o |=> (st_q.phase == PH_IDLE));

    // R7
    busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_o && start_i && !last_o) |=>
            ((st_q.phase == PH_OPEN) && (st_q.cnt == $past(st_q.cnt) + 1'b1)));

endmodule

// File: rtl/vfc_tally.sv
module vfc_tally #(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             enable_i,
    input  logic             rise_i,
    input  logic             last_i,
    output logic [CNT_W-1:0] code_o,
    output logic             ovf_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] CODE_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] acc;
        logic             sat;
        logic [CNT_W-1:0] code;
        logic             ovf;
        logic             done;
    } tally_st_t;

    tally_st_t        st_d, st_q;
    logic [CNT_W-1:0] acc_step;
    logic             sat_step;

    always_comb begin
        acc_step = st_q.acc;
        sat_step = st_q.sat;
        if (enable_i && rise_i) begin
            if (st_q.acc == CODE_MAX) begin
                sat_step = 1'b1;
            end else begin
                acc_step = st_q.acc + 1'b1;
            end
        end

        st_d      = st_q;
        st_d.done = 1'b0;
        if (clear_i) begin
            st_d.acc = '0;
            st_d.sat = 1'b0;
        end else if (enable_i) begin
            st_d.acc = acc_step;
            st_d.sat = sat_step;
        end
        if (last_i) begin
            st_d.code = acc_step;
            st_d.ovf  = sat_step;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign ovf_o  = st_q.ovf;
    assign done_o = st_q.done;

    // R2
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R8
    result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(code_o) && $stable(ovf_o)));

    // R6
    ovf_at_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> (code_o == CODE_MAX));

    // R3
    acc_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !last_i) |=> (st_q.acc >= $past(st_q.acc)));

endmodule

// File: rtl/vfc_edge_tally.sv
module vfc_edge_tally #(
    parameter int GATE_CYCLES = 64,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             osc_i,
    input  logic             start_i,
    output logic [CNT_W-1:0] code_o,
    output logic             ovf_o,
    output logic             done_o
);

    logic rise;
    logic accept;
    logic active;
    logic last;

    vfc_osc_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .osc_i (osc_i),
        .rise_o(rise)
    );

    vfc_gate_timer #(
        .GATE_CYCLES(GATE_CYCLES)
    ) u_gate (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .accept_o(accept),
        .active_o(active),
        .last_o  (last)
    );

    vfc_tally #(
        .CNT_W(CNT_W)
    ) u_tally (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (accept),
        .enable_i(active),
        .rise_i  (rise),
        .last_i  (last),
        .code_o  (code_o),
        .ovf_o   (ovf_o),
        .done_o  (done_o)
    );

    // R2
    done_after_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(last));

    // R9
    clear_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |-> !active);

endmodule

// File: tb/sim_vfc_edge_tally.sv
module sim_vfc_edge_tally;

    localparam int N    = 64;
    localparam int W    = 4;
    localparam int MAXC = (1 << W) - 1;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic         osc   = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] code;
    logic         ovf;
    logic         done;

    always #4 clk = ~clk;

    vfc_edge_tally #(
        .GATE_CYCLES(N),
        .CNT_W      (W),
        .SYNC_STAGES(2)
    ) u0 (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .osc_i  (osc),
        .start_i(start),
        .code_o (code),
        .ovf_o  (ovf),
        .done_o (done)
    );

    typedef struct {
        int    code;
        bit    ovf;
        int    at;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   rq[$];
    int   cyc    = 0;
    int   nchk   = 0;
    int   nbad   = 0;
    bit   wd_hit = 1'b0;
    bit   ended  = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report(input bit ok, input string req, input string what,
                          input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: schedules start and oscillator rises, pushes the expected result.
    task automatic conv(input int lead, input int extra, input int tail, input string tag);
        int   s;
        int   hits;
        bit   hi;
        exp_t e;
        s    = cyc + lead;
        hits = 0;
        foreach (rq[i]) if (rq[i] >= -1 && rq[i] <= N - 2) hits++;
        e.code = (hits > MAXC) ? MAXC : hits;
        e.ovf  = (hits > MAXC);
        e.at   = s + N;
        e.tag  = tag;
        sbq.push_back(e);
        for (int c = cyc + 1; c <= s + N + tail; c++) begin
            hi = 1'b0;
            foreach (rq[i]) if (s + rq[i] == c) hi = 1'b1;
            osc   = hi;
            start = (c == s) || (extra > 0 && c == s + extra);
            @(negedge clk);
        end
        osc   = 1'b0;
        start = 1'b0;
        rq.delete();
    endtask

    // Monitor: pops expected items on each done pulse; checks holding otherwise (R8).
    logic [W-1:0] code_prev = '0;
    logic         ovf_prev  = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            if (done) begin
                if (sbq.size() == 0) begin
                    report(1'b0, "R7", "unexpected done pulse", 1, 0);
                end else begin
                    exp_t e2;
                    e2 = sbq.pop_front();
                    report(!$isunknown(code) && int'(code) == e2.code, e2.tag, "code",
                           int'(code), e2.code);
                    report(ovf === e2.ovf, e2.tag, "overflow flag", int'(ovf), int'(e2.ovf));
                    report(cyc == e2.at, "R2", "done cycle", cyc, e2.at);
                end
            end else if (code !== code_prev || ovf !== ovf_prev) begin
                report(1'b0, "R8", "result changed without done", int'(code), int'(code_prev));
            end
            code_prev <= code;
            ovf_prev  <= ovf;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            wd_hit = 1'b1;
            ended  = 1'b1;
            report(1'b0, "R2", "watchdog expired", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        report(code === '0 && ovf === 1'b0 && done === 1'b0, "R1", "outputs in reset",
               int'({code, ovf, done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 after release
        report(code === '0 && ovf === 1'b0 && done === 1'b0, "R1", "outputs after reset",
               int'({code, ovf, done}), 0);

        // R4: no rises at all
        conv(6, 0, 4, "R4 empty window");

        // R5: a single rise, then a handful of spaced rises
        rq = '{10};
        conv(6, 0, 4, "R5 one rise");
        rq = '{3, 10, 17, 24, 31};
        conv(6, 0, 4, "R5 five rises");

        // R5: exactly the largest code, no overflow
        for (int i = 0; i < MAXC; i++) rq.push_back(i * 4);
        conv(6, 0, 4, "R5 full scale");

        // R6: one rise past full scale, then well past it
        for (int i = 0; i < MAXC + 1; i++) rq.push_back(i * 3);
        conv(6, 0, 4, "R6 one over");
        for (int i = 0; i < 20; i++) rq.push_back(i * 3);
        conv(6, 0, 4, "R6 far over");

        // R9: small count right after a saturated window
        rq = '{20, 40};
        conv(6, 0, 4, "R9 clear after saturation");

        // R3: window boundaries
        rq = '{-4, -2, N - 2, N};
        conv(6, 0, 4, "R3 edges around window");
        rq = '{-1, N - 4, N - 1, N + 1};
        conv(6, 0, 4, "R3 first and last slots");

        // R7: start mid-window and on the closing edge
        rq = '{5, 15, 25, 35};
        conv(6, 20, 4, "R7 start mid window");
        rq = '{8, 30};
        conv(6, N, 4, "R7 start on closing edge");

        // Collision: rise on final slot, then a start during the done cycle (R9)
        rq = '{N - 2};
        conv(6, 0, 0, "R3 rise on last slot");
        rq = '{0, 2, 4};
        conv(1, 0, 4, "R9 start during done");

        repeat (6) @(negedge clk);
        // R2: every expected done pulse appeared
        report(sbq.size() == 0, "R2", "missing done pulses", sbq.size(), 0);

        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

endmodule